// File: doc/BRIEF.md
# FPGA Slave-SPI Configuration Sequencer

This block acts as the SPI master that loads a configuration image into an SRAM-based FPGA wired as an SPI slave. It owns the target's active-low reset line, its chip-select, SCK and MOSI, and it watches the target's configuration-done output. Image bytes reach the block on a valid/ready byte stream whose final byte is flagged; a one-cycle start pulse begins a load job.

A job runs as follows. The target is held in reset with chip-select low, and then released. The block checks that the done line stayed low and waits out the target's internal housekeeping with chip-select still low. It then shifts the image out in SPI mode 0 (MSB first, SCK idles low), confirms that done has risen, and sends zero-filled activation bytes. Afterwards it reports success, or one of three error codes. When the block is idle and nothing has been loaded, it keeps the target in reset with chip-select low, so the target cannot start a boot of its own and drive the shared clock line.

All delays derive from a clock-frequency parameter. The SCK divider comes from a requested rate, and an SCK rate outside 1 MHz to 25 MHz stops elaboration. In the requirements, RST_CYC = RESET_US x ceil(CLK_HZ / 1e6), HK_CYC = HOUSEKEEP_US x ceil(CLK_HZ / 1e6), and HALF = CLK_HZ / (2 x SCK_HZ) clock cycles.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, cfg_rst_n_o and cfg_cs_n_o are low, cfg_sck_o is low, and busy_o, success_o, err_o and s_ready_o are all low.
- R2: A start_i pulse with partial_i low is accepted only while busy_o is low (idle, done or error). It raises busy_o, and cfg_rst_n_o is then low, with cfg_cs_n_o low, for exactly RST_CYC cycles. A start_i pulse while busy_o is high has no effect.
- R3: Three cycles after reset release, the synchronised done input is examined. If it is high, the job ends with err_code_o = 1, cfg_cs_n_o high, cfg_rst_n_o low and no SCK pulse.
- R4: After reset release, cfg_cs_n_o stays low for exactly 3 + HK_CYC cycles. It then goes high and stays high until the first image byte is taken.
- R5: Each byte is sent MSB first in SPI mode 0. MOSI is stable at every SCK rising edge, each SCK level lasts HALF cycles, and cfg_cs_n_o is low at every SCK rising edge.
- R6: s_ready_o is high only in the image phase, while no byte is being shifted and before the last-flagged byte. A byte is taken on a clock edge where s_valid_i and s_ready_o are both high, and gaps in s_valid_i do not alter the bytes sent.
- R7: Three cycles after the last image bit, the synchronised done input is examined. If it is low, the job ends with err_code_o = 2, cfg_cs_n_o high, cfg_rst_n_o low, and no activation clocks.
- R8: If done is high, ceil(49/8) = 7 zero bytes (56 SCK pulses) follow. The block then drives cfg_rst_n_o and cfg_cs_n_o high, raises success_o and lowers busy_o.
- R9: A start_i pulse with partial_i high while busy_o is low is refused with err_code_o = 3. The sequencer state and the cfg_rst_n_o, cfg_cs_n_o and cfg_sck_o pins do not change.
- R10: operating_o equals cfg_done_i delayed by exactly two clock cycles.
- R11: An accepted start clears err_code_o to 0 (err_o low), and success_o stays low until the new job completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a load job |
| partial_i | input | 1 | Qualifies start_i as a partial-reconfiguration request |
| s_valid_i | input | 1 | Image byte valid |
| s_data_i | input | 8 | Image byte |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Image byte can be taken |
| cfg_done_i | input | 1 | Target configuration-done line (asynchronous) |
| cfg_rst_n_o | output | 1 | Target active-low reset |
| cfg_cs_n_o | output | 1 | Target active-low chip-select |
| cfg_sck_o | output | 1 | SPI clock to the target |
| cfg_mosi_o | output | 1 | SPI data to the target |
| busy_o | output | 1 | A job is in progress |
| success_o | output | 1 | Last job completed and the target was activated |
| operating_o | output | 1 | Synchronised done line is high |
| err_o | output | 1 | An error code is held |
| err_code_o | output | 2 | 0 none, 1 reset check failed, 2 done missing after image, 3 partial refused |

## Verification
The assertions assume that cfg_done_i drops while the target is in reset and is not held high by a faulty target, except where a check deliberately forces it high. They also assume that s_valid_i is only raised during the image phase and held until it is taken. The bench models the target on the clock's falling edge: done clears whenever the reset pin is low, and it rises after the last image byte only in runs meant to pass. A separate stuck-high flag covers the reset-check failure. Stream bytes, start pulses and partial requests change only on falling edges and keep to the handshake. The one deliberate out-of-phase start is issued while a job is busy, to show that it is ignored.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  localparam int BYTE_W     = 8;
  localparam int SETTLE_CYC = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_PULSE,
    ST_RST_CHECK,
    ST_HOUSEKEEP,
    ST_LOAD,
    ST_DONE_CHECK,
    ST_ACTIVATE,
    ST_DONE,
    ST_ERROR
  } cfg_state_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_RESET  = 2'd1,
    ERR_CONFIG = 2'd2,
    ERR_UNSUP  = 2'd3
  } cfg_err_e;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift #(
  parameter int HALF_CYC = 5,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o
);

  localparam int DIV_W = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam int BIT_W = $clog2(BYTE_W);

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              tick;

  assign tick = (div_q == DIV_W'(HALF_CYC - 1));

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    sreg_d = sreg_q;
    bit_d  = bit_q;
    div_d  = div_q;
    if (load_i && !busy_q) begin
      busy_d = 1'b1;
      sreg_d = byte_i;
      bit_d  = '0;
      div_d  = '0;
      sck_d  = 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        div_d = '0;
        if (!sck_q) begin
          sck_d = 1'b1;
        end else begin
          sck_d  = 1'b0;
          sreg_d = {sreg_q[BYTE_W-2:0], 1'b0};
          bit_d  = bit_q + BIT_W'(1);
          if (bit_q == BIT_W'(BYTE_W - 1)) busy_d = 1'b0;
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      sreg_q <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign mosi_o = sreg_q[BYTE_W-1];

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader #(
  parameter int CLK_HZ       = 125_000_000,
  parameter int SCK_HZ       = 12_500_000,
  parameter int RESET_US     = 1,
  parameter int HOUSEKEEP_US = 1200,
  parameter int ACT_BITS     = 49,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       partial_i,
  input  logic                       s_valid_i,
  input  logic [cfgl_pkg::BYTE_W-1:0] s_data_i,
  input  logic                       s_last_i,
  output logic                       s_ready_o,
  input  logic                       cfg_done_i,
  output logic                       cfg_rst_n_o,
  output logic                       cfg_cs_n_o,
  output logic                       cfg_sck_o,
  output logic                       cfg_mosi_o,
  output logic                       busy_o,
  output logic                       success_o,
  output logic                       operating_o,
  output logic                       err_o,
  output logic [1:0]                 err_code_o
);

  import cfgl_pkg::*;

  localparam int CYC_PER_US = (CLK_HZ + 999_999) / 1_000_000;
  localparam int RST_CYC    = CYC_PER_US * RESET_US;
  localparam int HK_CYC     = CYC_PER_US * HOUSEKEEP_US;
  localparam int HALF_RAW   = CLK_HZ / (2 * SCK_HZ);
  localparam int HALF_CYC   = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int ACT_BYTES  = (ACT_BITS + BYTE_W - 1) / BYTE_W;
  localparam int LONGEST    = (HK_CYC > RST_CYC) ? HK_CYC : RST_CYC;
  localparam int DLY_W      = $clog2(LONGEST + SETTLE_CYC + 1);
  localparam int ACT_W      = $clog2(ACT_BYTES + 1);

  // Elaboration guard on the SCK rate and on the timing parameters
  if (SCK_HZ > 25_000_000 || SCK_HZ < 1_000_000 || HALF_RAW < 1 ||
      (CLK_HZ / (2 * HALF_CYC)) < 1_000_000 || RESET_US < 1 ||
      HOUSEKEEP_US < 1 || ACT_BITS < 1 || SYNC_STAGES < 2) begin : g_bad_cfg
    $error("fpga_cfg_loader: SCK rate or timing parameter out of range");
  end

  cfg_state_e         state_q, state_d;
  cfg_err_e           err_q, err_d;
  logic [DLY_W-1:0]   dly_q, dly_d;
  logic [ACT_W-1:0]   act_q, act_d;
  logic               last_q, last_d;
  logic               started_q, started_d;
  logic               done_s;
  logic               sh_load, sh_busy;
  logic [BYTE_W-1:0]  sh_byte;
  logic               idle_like, go, refuse, timed, settle_hit;

  cfgl_sync #(.STAGES(SYNC_STAGES)) i_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cfg_done_i),
    .q_o   (done_s)
  );

  cfgl_shift #(.HALF_CYC(HALF_CYC), .BYTE_W(BYTE_W)) i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (sh_load),
    .byte_i (sh_byte),
    .busy_o (sh_busy),
    .sck_o  (cfg_sck_o),
    .mosi_o (cfg_mosi_o)
  );

  assign idle_like  = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERROR);
  assign go         = idle_like && start_i && !partial_i;
  assign refuse     = idle_like && start_i && partial_i;
  assign timed      = (state_q == ST_RST_PULSE) || (state_q == ST_RST_CHECK) ||
                      (state_q == ST_HOUSEKEEP) || (state_q == ST_DONE_CHECK);
  assign settle_hit = (dly_q == DLY_W'(SETTLE_CYC - 1));

  assign s_ready_o = (state_q == ST_LOAD) && !sh_busy && !last_q;
  assign sh_load   = ((state_q == ST_LOAD) && s_valid_i && s_ready_o) ||
                     ((state_q == ST_ACTIVATE) && !sh_busy && (act_q < ACT_W'(ACT_BYTES)));
  assign sh_byte   = (state_q == ST_LOAD) ? s_data_i : '0;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    err_d     = err_q;
    last_d    = last_q;
    started_d = started_q;
    act_d     = act_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_ERROR: begin
        if (go) begin
          state_d   = ST_RST_PULSE;
          err_d     = ERR_NONE;
          last_d    = 1'b0;
          started_d = 1'b0;
          act_d     = '0;
        end else if (refuse) begin
          err_d = ERR_UNSUP;
        end
      end
      ST_RST_PULSE: if (dly_q == DLY_W'(RST_CYC - 1)) state_d = ST_RST_CHECK;
      ST_RST_CHECK: begin
        if (settle_hit) begin
          if (done_s) begin
            state_d = ST_ERROR;
            err_d   = ERR_RESET;
          end else begin
            state_d = ST_HOUSEKEEP;
          end
        end
      end
      ST_HOUSEKEEP: if (dly_q == DLY_W'(HK_CYC - 1)) state_d = ST_LOAD;
      ST_LOAD: begin
        if (sh_load) begin
          started_d = 1'b1;
          if (s_last_i) last_d = 1'b1;
        end
        if (last_q && !sh_busy) state_d = ST_DONE_CHECK;
      end
      ST_DONE_CHECK: begin
        if (settle_hit) begin
          if (done_s) begin
            state_d = ST_ACTIVATE;
          end else begin
            state_d = ST_ERROR;
            err_d   = ERR_CONFIG;
          end
        end
      end
      ST_ACTIVATE: begin
        if (sh_load) act_d = act_q + ACT_W'(1);
        if (act_q == ACT_W'(ACT_BYTES) && !sh_busy) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (state_d != state_q) dly_d = '0;
    else if (timed)         dly_d = dly_q + DLY_W'(1);
    else                    dly_d = dly_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      err_q     <= ERR_NONE;
      dly_q     <= '0;
      act_q     <= '0;
      last_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      err_q     <= err_d;
      dly_q     <= dly_d;
      act_q     <= act_d;
      last_q    <= last_d;
      started_q <= started_d;
    end
  end

  // Pin and status decode
  always_comb begin
    cfg_rst_n_o = 1'b1;
    cfg_cs_n_o  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_RST_PULSE: cfg_rst_n_o = 1'b0;
      ST_LOAD:               cfg_cs_n_o  = !started_q;
      ST_DONE:               cfg_cs_n_o  = 1'b1;
      ST_ERROR: begin
        cfg_rst_n_o = 1'b0;
        cfg_cs_n_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy_o      = !idle_like;
  assign success_o   = (state_q == ST_DONE);
  assign operating_o = done_s;
  assign err_o       = (err_q != ERR_NONE);
  assign err_code_o  = err_q;

endmodule

// File: rtl/fpga_cfg_loader_chk.sv
module fpga_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       partial_i,
  input logic       s_valid_i,
  input logic       s_ready_o,
  input logic       cfg_done_i,
  input logic       cfg_rst_n_o,
  input logic       cfg_cs_n_o,
  input logic       cfg_sck_o,
  input logic       cfg_mosi_o,
  input logic       busy_o,
  input logic       success_o,
  input logic       operating_o,
  input logic [1:0] err_code_o
);

  logic [1:0] since_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst_q <= 2'd0;
    else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
  end

  assert_start_holds_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !partial_i) |=> (busy_o && !cfg_rst_n_o && !cfg_cs_n_o));

  assert_rstfail_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code_o == 2'd1) |-> (!busy_o && !cfg_rst_n_o && cfg_cs_n_o && !cfg_sck_o));

  assert_sck_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sck_o |-> !cfg_cs_n_o);

  assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_sck_o) |-> $stable(cfg_mosi_o));

  assert_ready_scope_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (busy_o && cfg_rst_n_o && !cfg_sck_o));

  assert_one_byte_per_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o) |=> !s_ready_o);

  assert_cfgfail_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code_o == 2'd2) |-> (!busy_o && !cfg_rst_n_o && cfg_cs_n_o));

  assert_success_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    success_o |-> (cfg_rst_n_o && cfg_cs_n_o && !busy_o));

  assert_partial_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && partial_i) |=>
      ($stable(cfg_rst_n_o) && $stable(cfg_cs_n_o) && !busy_o && err_code_o == 2'd3));

  assert_operating_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q == 2'd2) |-> (operating_o == $past(cfg_done_i, 2)));

endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk i_chk (.*);

// File: tb/test_fpga_cfg_loader.sv
module test_fpga_cfg_loader;

  localparam int RST_W  = 125;
  localparam int HK_W   = 250;
  localparam int SETTLE = 3;
  localparam int ACT_N  = 7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, partial_i, s_valid_i, s_last_i;
  logic [7:0] s_data_i;
  logic       s_ready_o, cfg_done_i, cfg_rst_n_o, cfg_cs_n_o, cfg_sck_o, cfg_mosi_o;
  logic       busy_o, success_o, operating_o, err_o;
  logic [1:0] err_code_o;

  logic       tgt_done, stuck_done, done_on_image;
  int         checks, errors, rises, mon_bytes, img_target, nbits, cyc;
  logic [7:0] shin;
  logic [7:0] exp_q[$];
  logic [7:0] img[$];

  assign cfg_done_i = tgt_done | stuck_done;

  always #4 clk = ~clk;

  fpga_cfg_loader #(
    .CLK_HZ(125_000_000), .SCK_HZ(12_500_000), .RESET_US(1), .HOUSEKEEP_US(2)
  ) i_fpga_cfg_loader (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: rebuilds each byte at SCK rising edges and scores it
  always @(posedge cfg_sck_o) begin
    shin = {shin[6:0], cfg_mosi_o};
    nbits++;
    rises++;
    if (cfg_cs_n_o) check(0, "R5", "cs high at sck rise", 1, 0);
    if (nbits == 8) begin
      nbits = 0;
      mon_bytes++;
      if (exp_q.size() == 0) begin
        check(0, "R5", "unexpected byte", int'(shin), -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(shin == e, "R5", "byte on MOSI", int'(shin), int'(e));
      end
      if (done_on_image && mon_bytes == img_target) tgt_done = 1'b1;
    end
  end

  // Target model: done clears while the target is held in reset
  always @(negedge clk) if (!cfg_rst_n_o) tgt_done = 1'b0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic start_job(output int rst_w, output int cs_w);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(busy_o && !err_o, "R11", "busy with cleared error", int'(err_code_o), 0);
    rst_w = 0;
    while (!cfg_rst_n_o && busy_o) begin rst_w++; @(negedge clk); end
    cs_w = 0;
    while (!cfg_cs_n_o) begin cs_w++; @(negedge clk); end
  endtask

  task automatic run_job(input bit expect_ok, input int gap, input bit poke_start);
    int rw, cw;
    mon_bytes = 0; rises = 0; nbits = 0;
    img_target = img.size();
    done_on_image = expect_ok;
    start_job(rw, cw);
    check(rw == RST_W, "R2", "reset low width", rw, RST_W);
    check(cw == SETTLE + HK_W, "R4", "cs low after release", cw, SETTLE + HK_W);
    check(cfg_cs_n_o && busy_o && cfg_rst_n_o, "R4", "cs high before first byte",
          int'(cfg_cs_n_o), 1);
    for (int i = 0; i < img.size(); i++) begin
      exp_q.push_back(img[i]);
      s_valid_i = 1'b1; s_data_i = img[i]; s_last_i = (i == img.size() - 1);
      while (!s_ready_o) @(negedge clk);
      @(negedge clk);
      s_valid_i = 1'b0; s_last_i = 1'b0;
      check(!s_ready_o, "R6", "ready low while shifting", int'(s_ready_o), 0);
      if (poke_start && i == 1) begin
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      end
      repeat (gap) @(negedge clk);
    end
    if (expect_ok) for (int k = 0; k < ACT_N; k++) exp_q.push_back(8'h00);
    while (busy_o) @(negedge clk);
    check(exp_q.size() == 0, expect_ok ? "R8" : "R7", "bytes left unsent", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    bit quiet;
    int rw, cw;
    checks = 0; errors = 0; cyc = 0; nbits = 0; shin = '0;
    rst_n = 1'b0; start_i = 1'b0; partial_i = 1'b0; s_valid_i = 1'b0;
    s_last_i = 1'b0; s_data_i = '0; tgt_done = 1'b0; stuck_done = 1'b0;
    done_on_image = 1'b0; mon_bytes = 0; rises = 0; img_target = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!cfg_rst_n_o && !cfg_cs_n_o && !cfg_sck_o, "R1", "pins after reset",
          {cfg_rst_n_o, cfg_cs_n_o, cfg_sck_o}, 0);
    check(!busy_o && !success_o && !err_o && !s_ready_o, "R1", "status after reset",
          {busy_o, success_o, err_o, s_ready_o}, 0);

    // R10 two-cycle synchroniser
    stuck_done = 1'b1;
    @(negedge clk);
    check(!operating_o, "R10", "operating after one cycle", int'(operating_o), 0);
    @(negedge clk);
    check(operating_o, "R10", "operating after two cycles", int'(operating_o), 1);
    stuck_done = 1'b0;
    repeat (3) @(negedge clk);

    // R9 partial refused in idle
    start_i = 1'b1; partial_i = 1'b1;
    @(negedge clk) start_i = 1'b0; partial_i = 1'b0;
    check(err_code_o == 2'd3 && !busy_o, "R9", "partial refused in idle", int'(err_code_o), 3);
    quiet = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (cfg_rst_n_o || cfg_cs_n_o || cfg_sck_o) quiet = 1'b0;
    end
    check(quiet, "R9", "idle pins unchanged", int'(quiet), 1);

    // R5 R6 R8 R11: good load with back-to-back bytes and a stray start
    img = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81};
    run_job(1'b1, 0, 1'b1);
    check(success_o && cfg_rst_n_o && cfg_cs_n_o, "R8", "pins after activation",
          {success_o, cfg_rst_n_o, cfg_cs_n_o}, 7);
    check(rises == (5 + ACT_N) * 8, "R8", "total sck pulses", rises, (5 + ACT_N) * 8);
    check(!err_o, "R11", "no error after good load", int'(err_code_o), 0);

    // R9 partial refused after success
    @(negedge clk) start_i = 1'b1; partial_i = 1'b1;
    @(negedge clk) start_i = 1'b0; partial_i = 1'b0;
    quiet = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (!cfg_rst_n_o || !cfg_cs_n_o || cfg_sck_o || !success_o) quiet = 1'b0;
    end
    check(quiet && err_code_o == 2'd3, "R9", "done state kept on partial", int'(err_code_o), 3);

    // R3 reset check failure (done stuck high)
    stuck_done = 1'b1; rises = 0;
    start_job(rw, cw);
    check(rw == RST_W, "R2", "reset low width before check", rw, RST_W);
    check(cw == SETTLE, "R3", "cs low cycles before abort", cw, SETTLE);
    check(err_code_o == 2'd1 && !busy_o, "R3", "reset-fail code", int'(err_code_o), 1);
    check(!cfg_rst_n_o && cfg_cs_n_o && rises == 0, "R3", "pins after reset fail",
          rises, 0);
    stuck_done = 1'b0;
    repeat (4) @(negedge clk);

    // R2 R6 R8: restart from error with gaps in the stream
    img = '{8'h01, 8'h80, 8'h7E};
    run_job(1'b1, 3, 1'b0);
    check(success_o && !err_o, "R8", "success after gapped load", int'(err_code_o), 0);
    check(rises == (3 + ACT_N) * 8, "R6", "sck pulses with gaps", rises, (3 + ACT_N) * 8);

    // R7 done missing after image
    img = '{8'hC3, 8'h5A};
    run_job(1'b0, 1, 1'b0);
    check(err_code_o == 2'd2 && !success_o, "R7", "config-fail code", int'(err_code_o), 2);
    check(rises == 2 * 8, "R7", "no activation clocks", rises, 16);
    check(!cfg_rst_n_o && cfg_cs_n_o, "R7", "pins after config fail",
          {cfg_rst_n_o, cfg_cs_n_o}, 1);

    summary();
    $finish;
  end

endmodule